// File: doc/BRIEF.md
# Bus Arbitration Phase Controller

This block is the one central sequencer of a shared-bus arbitration scheme. Any agent that wants the bus pulls the shared active-low `preempt_n` line. The controller then moves the bus into the arbitration phase. It holds that phase long enough for the distributed contenders to settle their priority comparison among themselves, and then returns the bus to the grant phase so that the winner can drive it. The controller never picks the winner among devices. It only decides when each phase starts and when it ends.

A device that holds the bus for a long transfer keeps `burst_n` low. A new request ends such a burst, because the controller enters arbitration and waits for the burst owner to let go. If the owner does not let go within a fixed time, the controller raises a sticky error. While that error is set, every grant falls straight back into arbitration.

The controller also schedules memory refresh at a fixed interval. Refresh is a requester that ranks above every device, including the highest-priority one. A refresh that falls due while the bus is owned waits as pending. It then takes the next grant ahead of all device levels. Both intervals are given in nanoseconds and are turned into clock counts from the clock-frequency parameter.

Top module: `bus_arb_ctrl`

## Requirements
- R1: When `preempt_n` is low in a grant phase that has no refresh in progress, `arb_phase` goes high on the next clock. `arb_phase` high means arbitration and low means grant.
- R2: Once the bus is free (`burst_n` high, or the error set), the arbitration phase lasts exactly SETTLE_CYC clocks. After that, `dev_grant` or `refresh_grant` goes high.
- R3: `dev_grant` and `refresh_grant` are never high while `arb_phase` is high. Each grant is entered only directly from an arbitration phase.
- R4: A request that arrives while a device owns the bus starts a new arbitration. The settle count does not advance while `burst_n` stays low, so no grant is issued until the burst owner releases.
- R5: If `burst_n` stays low for TIMEOUT_NS × CLK_MHZ / 1000 clocks of arbitration (390 at the defaults), `timeout_err` goes high on the next clock.
- R6: A refresh falls due every REFRESH_NS × CLK_MHZ / 1000 clocks (750 at the defaults) and stays pending until it is granted. A pending refresh wins the next grant over any device and holds `refresh_grant` for REF_LEN_CYC clocks. The bus then returns to a grant phase with no owner.
- R7: `timeout_err` stays high until `err_clr` is sampled high, and `err_clr` takes effect on the next clock. While the error is set, a device grant lasts one clock and is followed by arbitration, and burst holding no longer stalls the settle count.
- R8: Reset is synchronous and active high. It leaves the controller in a grant phase with no owner, no refresh pending and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preempt_n | input | 1 | Shared bus request, active low |
| burst_n | input | 1 | Current owner is holding the bus for a burst, active low |
| err_clr | input | 1 | Clears the timeout error |
| arb_phase | output | 1 | 1 = arbitration phase, 0 = grant phase |
| dev_grant | output | 1 | Grant phase with a device owning the bus |
| refresh_grant | output | 1 | Grant phase with memory refresh owning the bus |
| timeout_err | output | 1 | Sticky burst-release timeout error |

## Verification
If the phase state is wrong, it shows on `arb_phase` or on a grant output in the very next cycle. The reference model follows the phases every clock, so such a divergence is flagged at once. A wrong settle, timeout or refresh counter stays hidden until its terminal count. It then shows as a grant one cycle early or late, an error edge at the wrong clock, or a refresh grant that is missing or out of place. The directed phases therefore land exactly on those terminal counts. A long random phase with sticky bursts and occasional clears then covers the overlaps between refresh, timeout and preemption.

// File: rtl/bac_pkg.sv
package bac_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // grant phase, no owner
        PH_ARB  = 2'd1,   // arbitration settling
        PH_DEV  = 2'd2,   // grant phase, device owns bus
        PH_REF  = 2'd3    // grant phase, refresh owns bus
    } phase_e;

    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
        return (ns * mhz) / 1000;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/bac_refresh_sched.sv
module bac_refresh_sched
    import bac_pkg::*;
#(
    parameter int unsigned REF_CYC = 750
) (
    input  logic clk,
    input  logic rst,
    input  logic consume_i,
    output logic pend_o
);
    localparam int unsigned W = cnt_width(REF_CYC);
    localparam logic [W-1:0] LAST = W'(REF_CYC - 1);

    logic [W-1:0] cnt_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            pend_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (consume_i) pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !consume_i) |=> pend_q);
endmodule

// File: rtl/bac_release_timer.sv
module bac_release_timer
    import bac_pkg::*;
#(
    parameter int unsigned TO_CYC = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic in_arb_i,
    input  logic burst_n_i,
    input  logic clr_i,
    output logic err_o
);
    localparam int unsigned W = cnt_width(TO_CYC);
    localparam logic [W-1:0] LAST = W'(TO_CYC - 1);

    logic [W-1:0] cnt_q;
    logic         err_q;
    logic         hit;

    assign hit = in_arb_i && !burst_n_i && !err_q && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!in_arb_i || hit) begin
            cnt_q <= '0;
        end else if (!burst_n_i && !err_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        err_q <= 1'b0;
        else if (clr_i) err_q <= 1'b0;
        else if (hit)   err_q <= 1'b1;
    end

    assign err_o = err_q;

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_i) |=> err_q);
    // R5
    err_needs_burst_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(in_arb_i && !burst_n_i));
endmodule

// File: rtl/bac_phase_seq.sv
module bac_phase_seq
    import bac_pkg::*;
#(
    parameter int unsigned SETTLE_CYC  = 4,
    parameter int unsigned REF_LEN_CYC = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   preempt_n_i,
    input  logic   burst_n_i,
    input  logic   ref_pend_i,
    input  logic   err_i,
    output phase_e phase_o,
    output logic   consume_o
);
    localparam int unsigned SW = cnt_width(SETTLE_CYC);
    localparam int unsigned RW = cnt_width(REF_LEN_CYC);
    localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [RW-1:0] R_LAST = RW'(REF_LEN_CYC - 1);

    phase_e        phase_q;
    logic [SW-1:0] settle_q;
    logic [RW-1:0] rlen_q;
    logic          req, freed, settled;

    assign req     = !preempt_n_i || ref_pend_i || err_i;
    assign freed   = burst_n_i || err_i;
    assign settled = (phase_q == PH_ARB) && freed && (settle_q == S_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            settle_q <= '0;
            rlen_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_DEV: begin
                    settle_q <= '0;
                    if (req) phase_q <= PH_ARB;
                end
                PH_ARB: begin
                    if (settled) begin
                        settle_q <= '0;
                        rlen_q   <= '0;
                        phase_q  <= ref_pend_i ? PH_REF : PH_DEV;
                    end else if (freed) begin
                        settle_q <= settle_q + 1'b1;
                    end
                end
                default: begin
                    if (rlen_q == R_LAST) phase_q <= PH_IDLE;
                    else                  rlen_q  <= rlen_q + 1'b1;
                end
            endcase
        end
    end

    assign phase_o   = phase_q;
    assign consume_o = settled && ref_pend_i;

    // R1
    preempt_starts_arb_chk: assert property (@(posedge clk) disable iff (rst)
        (!preempt_n_i && phase_q == PH_IDLE) |=> phase_q == PH_ARB);
    // R2
    settle_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(phase_q) == PH_ARB && phase_q != PH_ARB) |-> $past(burst_n_i || err_i));
    // R3
    grant_after_arb_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_DEV || phase_q == PH_REF) && $past(phase_q) != phase_q)
            |-> $past(phase_q) == PH_ARB);
    // R7
    err_forces_arb_chk: assert property (@(posedge clk) disable iff (rst)
        (err_i && phase_q == PH_DEV) |=> phase_q == PH_ARB);
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl
    import bac_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 50,
    parameter int unsigned SETTLE_CYC  = 4,
    parameter int unsigned REF_LEN_CYC = 4,
    parameter int unsigned TIMEOUT_NS  = 7800,
    parameter int unsigned REFRESH_NS  = 15000
) (
    input  logic clk,
    input  logic rst,
    input  logic preempt_n,
    input  logic burst_n,
    input  logic err_clr,
    output logic arb_phase,
    output logic dev_grant,
    output logic refresh_grant,
    output logic timeout_err
);
    localparam int unsigned TO_CYC  = ns_to_cycles(TIMEOUT_NS, CLK_MHZ);
    localparam int unsigned REF_CYC = ns_to_cycles(REFRESH_NS, CLK_MHZ);

    phase_e phase;
    logic   ref_pend, consume, err;

    bac_refresh_sched #(.REF_CYC(REF_CYC)) u_ref (
        .clk(clk), .rst(rst), .consume_i(consume), .pend_o(ref_pend)
    );

    bac_release_timer #(.TO_CYC(TO_CYC)) u_tmr (
        .clk(clk), .rst(rst), .in_arb_i(phase == PH_ARB),
        .burst_n_i(burst_n), .clr_i(err_clr), .err_o(err)
    );

    bac_phase_seq #(.SETTLE_CYC(SETTLE_CYC), .REF_LEN_CYC(REF_LEN_CYC)) u_seq (
        .clk(clk), .rst(rst), .preempt_n_i(preempt_n), .burst_n_i(burst_n),
        .ref_pend_i(ref_pend), .err_i(err), .phase_o(phase), .consume_o(consume)
    );

    assign arb_phase     = (phase == PH_ARB);
    assign dev_grant     = (phase == PH_DEV);
    assign refresh_grant = (phase == PH_REF);
    assign timeout_err   = err;
endmodule

// File: tb/sim_bus_arb_ctrl.sv
module sim_bus_arb_ctrl;
    localparam int SETTLE = 4;
    localparam int RLEN   = 4;
    localparam int TO     = 7800 * 50 / 1000;
    localparam int REF    = 15000 * 50 / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic preempt_n = 1'b1, burst_n = 1'b1, err_clr = 1'b0;
    logic arb_phase, dev_grant, refresh_grant, timeout_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bus_arb_ctrl u0 (
        .clk(clk), .rst(rst), .preempt_n(preempt_n), .burst_n(burst_n),
        .err_clr(err_clr), .arb_phase(arb_phase), .dev_grant(dev_grant),
        .refresh_grant(refresh_grant), .timeout_err(timeout_err)
    );

    always #10 clk = ~clk;

    // behavioural reference: 0 idle, 1 arbitrating, 2 device, 3 refresh
    int m_st, m_settle, m_rlen, m_to, m_ref;
    bit m_err, m_pend;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_settle = 0; m_rlen = 0; m_to = 0; m_ref = 0;
            m_err = 0; m_pend = 0;
        end else begin
            bit req, go, n_err, n_pend;
            int n_st, n_to;
            req   = !preempt_n || m_pend || m_err;
            go    = (m_st == 1) && (burst_n || m_err) && (m_settle == SETTLE - 1);
            n_err = m_err; n_to = m_to;
            if (m_st != 1) n_to = 0;
            else if (!burst_n && !m_err) begin
                if (m_to == TO - 1) begin n_err = 1; n_to = 0; end
                else n_to = m_to + 1;
            end
            if (err_clr) n_err = 0;
            n_pend = m_pend;
            if (m_ref == REF - 1) begin m_ref = 0; n_pend = 1; end
            else begin
                m_ref = m_ref + 1;
                if (go && m_pend) n_pend = 0;
            end
            n_st = m_st;
            if (m_st == 0 || m_st == 2) begin
                m_settle = 0;
                if (req) n_st = 1;
            end else if (m_st == 1) begin
                if (go) begin m_settle = 0; m_rlen = 0; n_st = m_pend ? 3 : 2; end
                else if (burst_n || m_err) m_settle = m_settle + 1;
            end else begin
                if (m_rlen == RLEN - 1) n_st = 0;
                else m_rlen = m_rlen + 1;
            end
            m_st = n_st; m_err = n_err; m_pend = n_pend; m_to = n_to;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(arb_phase == (m_st == 1), "R1 arb_phase vs model", arb_phase, m_st == 1);
            chk(dev_grant == (m_st == 2), "R2 dev_grant vs model", dev_grant, m_st == 2);
            chk(refresh_grant == (m_st == 3), "R6 refresh_grant vs model", refresh_grant, m_st == 3);
            chk(timeout_err == m_err, "R5 timeout_err vs model", timeout_err, m_err);
            chk(!(arb_phase && (dev_grant || refresh_grant)), "R3 grant during arbitration",
                dev_grant || refresh_grant, 0);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int rcnt;
        step(3);
        chk(!arb_phase && !dev_grant && !refresh_grant && !timeout_err, "R8 reset state",
            {arb_phase, dev_grant, refresh_grant, timeout_err}, 0);
        rst = 1'b0;
        step(2);
        // R1 / R2: plain request
        preempt_n = 1'b0;
        step(1);
        chk(arb_phase == 1, "R1 arbitration after preempt", arb_phase, 1);
        preempt_n = 1'b1;
        step(SETTLE - 1);
        chk(arb_phase == 1 && !dev_grant, "R2 still settling", dev_grant, 0);
        step(1);
        chk(dev_grant == 1, "R2 grant after settle", dev_grant, 1);
        // R4: preempt during a burst
        burst_n = 1'b0;
        step(3);
        preempt_n = 1'b0;
        step(1);
        preempt_n = 1'b1;
        chk(arb_phase == 1, "R4 burst owner preempted", arb_phase, 1);
        step(30);
        chk(arb_phase == 1 && !dev_grant, "R4 waits for burst release", dev_grant, 0);
        burst_n = 1'b1;
        step(SETTLE);
        chk(dev_grant == 1, "R4 grant after release", dev_grant, 1);
        // R5: timeout
        burst_n = 1'b0;
        step(2);
        preempt_n = 1'b0;
        step(1);
        preempt_n = 1'b1;
        step(TO - 1);
        chk(timeout_err == 0, "R5 no error before limit", timeout_err, 0);
        step(1);
        chk(timeout_err == 1, "R5 error at limit", timeout_err, 1);
        // R7: sticky error forces re-arbitration
        rcnt = 0;
        while (!dev_grant && rcnt < 20) begin step(1); rcnt++; end
        chk(dev_grant == 1, "R7 grant despite held burst", dev_grant, 1);
        step(1);
        chk(arb_phase == 1, "R7 grant reverts to arbitration", arb_phase, 1);
        step(10);
        chk(timeout_err == 1, "R7 error sticky", timeout_err, 1);
        burst_n = 1'b1;
        err_clr = 1'b1;
        step(1);
        err_clr = 1'b0;
        chk(timeout_err == 0, "R7 error cleared", timeout_err, 0);
        // R6: refresh wins over a standing device request
        preempt_n = 1'b0;
        rcnt = 0;
        while (!refresh_grant && rcnt < REF + 20) begin step(1); rcnt++; end
        chk(refresh_grant == 1, "R6 refresh granted", refresh_grant, 1);
        rcnt = 0;
        while (refresh_grant && rcnt < 20) begin step(1); rcnt++; end
        chk(rcnt == RLEN, "R6 refresh length", rcnt, RLEN);
        preempt_n = 1'b1;
        step(20);
        // random mix
        for (int i = 0; i < 20000; i++) begin
            preempt_n = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 15) == 0) burst_n = ~burst_n;
            err_clr = ($urandom_range(0, 63) == 0);
            step(1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule